// File: doc/BRIEF.md
# Separable 3x3 Median Filter

This block smooths a streaming 8-bit grayscale image with an approximate 3x3 median. The row buffers live outside the block, so every clock it may be handed one column of the neighbourhood: the pixel from the newest row and the pixels at the same column from the two rows above it. Each row stream keeps its own two-pixel history. The block takes the median of the three horizontally adjacent pixels in each row, then the median of those three row results. This removes isolated impulse noise while keeping edges sharp.

The datapath uses only magnitude comparators and 2-to-1 selectors. No sorting network and no adder appear anywhere. A register follows each compare-select stage, so the result leaves two clock edges after the column that completes its window. A column counter that wraps at the image width suppresses results whose window would reach back into the previous line.

Top module: `sep_median3x3`

## Requirements
- R1: Pixels are unsigned and PIX_W (default 8) bits wide. For each row input, the row result is the median of the pixel just accepted and the two pixels accepted on that row before it.
- R2: The output pixel is the median of the three row results of the same column. A single extreme pixel inside a flat neighbourhood is therefore removed.
- R3: out_valid is high exactly two rising edges after the edge that accepted a pixel (in_valid high) whose column index is 2 or more. Otherwise out_valid is low.
- R4: The column index counts accepted pixels from 0 and wraps to 0 after IMG_W (default 512) accepted pixels. Columns 0 and 1 of every line never produce a valid output, so a full line gives IMG_W-2 results.
- R5: While in_valid is low, the row histories and the column index hold. A gap of any length between pixels does not change the results.
- R6: Ties resolve to the tied value. A window whose nine pixels are all equal yields that same value.
- R7: While rst_n is low, out_valid and out_pix are 0 and the column index returns to 0.
- R8: Each valid output value equals one of the three row results it was formed from, because only selection is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when the three row pixels are to be accepted this edge |
| pix_row0 | input | PIX_W | Pixel of the newest row |
| pix_row1 | input | PIX_W | Pixel of the row one line earlier, same column |
| pix_row2 | input | PIX_W | Pixel of the row two lines earlier, same column |
| out_valid | output | 1 | High when out_pix holds a new filtered pixel |
| out_pix | output | PIX_W | Filtered pixel, held between valid outputs |

## Verification
A fixed table of hand-chosen columns checks the order of the selectors. It includes descending, ascending and mixed triples, so a selector that picks the maximum or the minimum in place of the median shows up. Random pixels over several lines check the full two-level median and the line wrap. Random idle gaps between pixels separate correct holding from history corruption. An all-equal field and a flat field with single full-scale spikes cover the tie rules and impulse rejection. A line-length count confirms that exactly two columns per line are suppressed.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int SM_TAPS = 3;   // pixels per row window and rows per column
  localparam int SM_LAT  = 2;   // register stages from accept to output
  localparam int SM_SKIP = 2;   // leading columns of each line with no result
endpackage

// File: rtl/sm_med3.sv
// Median of three by compare-select: max(min(a,b), min(max(a,b), c)).
module sm_med3 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] med
);
  logic         a_gt_b;
  logic         hi_gt_c;
  logic         lo_gt_mid;
  logic [W-1:0] hi;
  logic [W-1:0] lo;
  logic [W-1:0] mid;

  always_comb begin
    a_gt_b    = a > b;
    hi        = a_gt_b ? a : b;
    lo        = a_gt_b ? b : a;
    hi_gt_c   = hi > c;
    mid       = hi_gt_c ? c : hi;
    lo_gt_mid = lo > mid;
    med       = lo_gt_mid ? lo : mid;
  end
endmodule

// File: rtl/sm_row_window.sv
// Two-pixel history of one row plus the registered horizontal median.
module sm_row_window #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] pix_in,
  output logic [W-1:0] tap1,
  output logic [W-1:0] tap2,
  output logic [W-1:0] hmed
);
  logic [W-1:0] med_c;

  sm_med3 #(.W(W)) u_hmed (
    .a   (pix_in),
    .b   (tap1),
    .c   (tap2),
    .med (med_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap1 <= '0;
      tap2 <= '0;
      hmed <= '0;
    end else if (adv) begin
      tap1 <= pix_in;
      tap2 <= tap1;
      hmed <= med_c;
    end
  end
endmodule

// File: rtl/sm_col_track.sv
// Column index of accepted pixels, wrapping at the line width.
module sm_col_track #(
  parameter int IMG_W = 512,
  parameter int SKIP  = 2,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic          win_full
);
  localparam logic [CW-1:0] LAST = CW'(IMG_W - 1);
  localparam logic [CW-1:0] FIRST_OK = CW'(SKIP);

  assign win_full = col >= FIRST_OK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
    end else if (adv) begin
      col <= (col == LAST) ? '0 : col + 1'b1;
    end
  end
endmodule

// File: rtl/sep_median3x3.sv
module sep_median3x3
  import sm_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int IMG_W = 512,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] pix_row0,
  input  logic [PIX_W-1:0] pix_row1,
  input  logic [PIX_W-1:0] pix_row2,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix
);
  logic [PIX_W-1:0] row_in [SM_TAPS];
  logic [PIX_W-1:0] tap1   [SM_TAPS];
  logic [PIX_W-1:0] tap2   [SM_TAPS];
  logic [PIX_W-1:0] hmed   [SM_TAPS];
  logic [PIX_W-1:0] vmed_c;
  logic [CW-1:0]    col;
  logic             win_full;
  logic             h_valid;

  assign row_in[0] = pix_row0;
  assign row_in[1] = pix_row1;
  assign row_in[2] = pix_row2;

  sm_col_track #(.IMG_W(IMG_W), .SKIP(SM_SKIP)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (in_valid),
    .col      (col),
    .win_full (win_full)
  );

  for (genvar r = 0; r < SM_TAPS; r++) begin : g_row
    sm_row_window #(.W(PIX_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (in_valid),
      .pix_in (row_in[r]),
      .tap1   (tap1[r]),
      .tap2   (tap2[r]),
      .hmed   (hmed[r])
    );
  end

  sm_med3 #(.W(PIX_W)) u_vmed (
    .a   (hmed[0]),
    .b   (hmed[1]),
    .c   (hmed[2]),
    .med (vmed_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_valid   <= 1'b0;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      h_valid   <= in_valid && win_full;
      out_valid <= h_valid;
      if (h_valid) out_pix <= vmed_c;
    end
  end
endmodule

// File: rtl/sm_med_chk.sv
module sm_med_chk #(
  parameter int PIX_W = 8,
  parameter int IMG_W = 512,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] pix_row0,
  input logic [PIX_W-1:0] tap1_0,
  input logic [PIX_W-1:0] tap2_0,
  input logic [PIX_W-1:0] hmed0,
  input logic [PIX_W-1:0] hmed1,
  input logic [PIX_W-1:0] hmed2,
  input logic [CW-1:0]    col,
  input logic             win_full,
  input logic             h_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix
);
  // R1: row result is one of the three pixels of the row window
  a_r1_row_pick: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (hmed0 == $past(pix_row0) || hmed0 == $past(tap1_0) ||
                  hmed0 == $past(tap2_0)));

  // R8: output is one of the row results it was formed from
  a_r8_out_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) || (out_valid && $past(h_valid)) |->
      (out_pix == $past(hmed0) || out_pix == $past(hmed1) ||
       out_pix == $past(hmed2)));

  // R3: valid output only from an accepted pixel two edges back
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && win_full |=> h_valid);

  // R4: leading columns suppressed, index wraps at the line width
  a_r4_first_cols: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !win_full |=> !h_valid);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (col == CW'(IMG_W - 1)) |=> (col == '0));

  // R5: idle cycles leave history and column index untouched
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tap1_0) && $stable(tap2_0) && $stable(hmed0) &&
                  $stable(col));

  // R7: reset clears the output
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset: assert (!out_valid && out_pix == '0);
    end
  end
endmodule

bind sep_median3x3 sm_med_chk #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pix_row0  (pix_row0),
  .tap1_0    (tap1[0]),
  .tap2_0    (tap2[0]),
  .hmed0     (hmed[0]),
  .hmed1     (hmed[1]),
  .hmed2     (hmed[2]),
  .col       (col),
  .win_full  (win_full),
  .h_valid   (h_valid),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/tb_sep_median3x3.sv
module tb_sep_median3x3;
  localparam int PERIOD = 10;
  localparam int BW     = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] pix_row0, pix_row1, pix_row2;
  logic       out_valid;
  logic [7:0] out_pix;

  int checks = 0;
  int errors = 0;
  int ov_cnt = 0;
  int bcol   = 0;
  logic [7:0] hist [3][2];
  logic       pend_v, prev_v;
  logic [7:0] pend_p, prev_p;

  // stimulus columns: {row0, row1, row2}
  localparam logic [23:0] VEC [16] = '{
    24'h0A_14_1E, 24'h1E_14_0A, 24'h14_1E_0A, 24'hFF_00_80,
    24'h00_FF_80, 24'h80_80_01, 24'h05_F0_33, 24'h33_05_F0,
    24'hF0_33_05, 24'h10_10_10, 24'h7F_80_81, 24'h81_7F_80,
    24'h02_03_01, 24'hC8_64_32, 24'h32_C8_64, 24'h64_32_C8
  };

  always #(PERIOD/2) clk = ~clk;

  sep_median3x3 #(.PIX_W(8), .IMG_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pix_row0(pix_row0), .pix_row1(pix_row1), .pix_row2(pix_row2),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // median of three by exhaustive ordering
  function automatic logic [7:0] bmed(input logic [7:0] x, y, z);
    logic [7:0] s0, s1, s2, t;
    s0 = x; s1 = y; s2 = z;
    if (s0 > s1) begin t = s0; s0 = s1; s1 = t; end
    if (s1 > s2) begin t = s1; s1 = s2; s2 = t; end
    if (s0 > s1) begin t = s0; s0 = s1; s1 = t; end
    return s1;
  endfunction

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [7:0] a, b, c, input string tag);
    logic       ev;
    logic [7:0] ep;
    logic [7:0] px [3];
    px[0] = a; px[1] = b; px[2] = c;
    in_valid = v; pix_row0 = a; pix_row1 = b; pix_row2 = c;
    ev = 1'b0; ep = 8'd0;
    if (v) begin
      ep = bmed(bmed(a, hist[0][0], hist[0][1]),
                bmed(b, hist[1][0], hist[1][1]),
                bmed(c, hist[2][0], hist[2][1]));
      ev = (bcol >= 2);
      for (int r = 0; r < 3; r++) begin
        hist[r][1] = hist[r][0];
        hist[r][0] = px[r];
      end
      bcol = (bcol + 1) % BW;
    end
    prev_v = pend_v; prev_p = pend_p;
    pend_v = ev;     pend_p = ep;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R3 valid"}, out_valid == prev_v, out_valid, prev_v);
    if (prev_v) chk({tag, " pixel"}, out_pix == prev_p, out_pix, prev_p);
    if (out_valid) ov_cnt++;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    pix_row0 = '0; pix_row1 = '0; pix_row2 = '0;
    pend_v = 1'b0; prev_v = 1'b0; pend_p = '0; prev_p = '0;
    for (int r = 0; r < 3; r++) begin hist[r][0] = '0; hist[r][1] = '0; end
    repeat (3) @(negedge clk);
    chk("R7 reset valid", out_valid == 1'b0, out_valid, 0);
    chk("R7 reset pixel", out_pix == 8'd0, out_pix, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R8: table walk, contiguous
    for (int i = 0; i < 16; i++)
      cycle(1'b1, VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], "R2 table");

    // R5: same table with idle gaps
    for (int i = 0; i < 16; i++) begin
      cycle(1'b1, VEC[i][7:0], VEC[i][23:16], VEC[i][15:8], "R5 gaps");
      for (int g = 0; g < (i % 3); g++) cycle(1'b0, 8'hAA, 8'h55, 8'hAA, "R5 idle");
    end

    // R1: random pixels over several lines
    for (int i = 0; i < 40; i++)
      cycle(1'b1, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
            8'($urandom_range(0, 255)), "R1 random");

    // R5: random pixels with random idle cycles
    for (int i = 0; i < 40; i++)
      cycle(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
            8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), "R5 random");

    // R4: align to line start, then count results of one line
    while (bcol != 0) cycle(1'b1, 8'd1, 8'd2, 8'd3, "R4 align");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R4 flush");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R4 flush");
    ov_cnt = 0;
    for (int i = 0; i < BW; i++) cycle(1'b1, 8'(i * 9), 8'(i * 5), 8'(i * 7), "R4 line");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R4 drain");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R4 drain");
    chk("R4 results per line", ov_cnt == BW - 2, ov_cnt, BW - 2);

    // R6: all-equal field
    for (int i = 0; i < BW + 2; i++) cycle(1'b1, 8'd77, 8'd77, 8'd77, "R6 equal");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R6 drain");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R6 drain");
    chk("R6 equal value", out_pix == 8'd77, out_pix, 77);

    // R2: single spikes in a flat field are removed
    for (int i = 0; i < 2 * BW; i++)
      cycle(1'b1, (i == 5) ? 8'hFF : 8'd10, (i == 9) ? 8'hFF : 8'd10,
            (i == 12) ? 8'h00 : 8'd10, "R2 impulse");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R2 drain");
    cycle(1'b0, 8'd0, 8'd0, 8'd0, "R2 drain");
    chk("R2 impulse removed", out_pix == 8'd10, out_pix, 10);

    finish_run();
  end
endmodule